// File: doc/BRIEF.md
# Closed-Loop PWM Duty Regulator

This block closes a simple speed loop around a DC motor. Once per measurement window a strobe presents the measured speed as packed BCD digits. The block latches that value and compares it with a set speed chosen from a small table of presets. On each strobe a 4-bit duty register takes one step. It steps up when the motor is too slow and down when it is too fast, and it holds when the two speeds match. The register saturates at both ends.

The duty register feeds a fixed-period PWM generator. The period is split into 2^DUTY_W slots of STEP_CYCLES clocks each. Code n keeps the drive on for n+1 slots. The all-ones code keeps the same on-time as the code just below it, so the drive is never on for a whole period. The pin is active low because the external transistor stage energises the motor when its input is low. Three comparison flags (equal, faster, slower) report the latched speed against the current set speed, for LEDs.

Top module: `speed_loop_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `duty` = 0 and `pwm_n` = 1 (motor off), and the latched speed is cleared to 0.
- R2: `set_sel` picks the set speed from a preset table: code 0 → 3, 1 → 6, 2 → 9, 3 → 12 (default parameters).
- R3: Exactly one of `spd_eq`, `spd_gt`, `spd_lt` is high. `spd_gt` means latched speed > set speed, `spd_lt` means latched speed < set speed, and `spd_eq` means they are equal. The latched speed changes only on a `sample_stb` cycle.
- R4: On a `sample_stb` cycle, `speed_bcd` (low nibble ones digit, next nibble tens digit) is compared with the set speed. Below the set speed, `duty` rises by 1 in the next cycle. Above it, `duty` falls by 1. Equal leaves `duty` unchanged.
- R5: `duty` does not change in any cycle that follows a cycle without `sample_stb`, and a change of `set_sel` alone leaves `duty` unchanged.
- R6: `duty` saturates: a step up from 15 stays at 15, and a step down from 0 stays at 0.
- R7: The PWM period is 2^DUTY_W × STEP_CYCLES clocks, and `pwm_n` has exactly one falling edge per period, at its start.
- R8: For duty code n from 0 to 14, `pwm_n` is low for (n+1) × STEP_CYCLES clocks of each period.
- R9: Code 15 gives the same low time as code 14, so `pwm_n` is never low for a whole period.
- R10: A duty change takes effect only at the next period start. The period already running keeps its low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle pulse at the end of a measurement window |
| speed_bcd | input | 4×DIGITS | Measured speed, packed BCD, ones digit in the low nibble |
| set_sel | input | log2(NUM_PRESETS) | Preset selection for the set speed |
| pwm_n | output | 1 | Active-low motor drive |
| duty | output | DUTY_W | Current duty code |
| spd_eq | output | 1 | Latched speed equals set speed |
| spd_gt | output | 1 | Latched speed above set speed |
| spd_lt | output | 1 | Latched speed below set speed |

## Verification
A wrong duty register shows on `duty` one cycle after the strobe that disturbed it. It shows on `pwm_n` only at the next period start, so the bench compares the low time of a whole period, not single samples. A slot or step counter that slips changes the period length or the low count within one period. A stale speed latch shows on the flags as soon as `set_sel` moves, with no strobe needed. The saturation ends and the repeated top code are driven directly, because random stimulus rarely stays at a rail long enough to show a wrap.

// File: rtl/speed_loop_pkg.sv
package speed_loop_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    localparam int unsigned PRESET_FIELD_W = 16;

endpackage

// File: rtl/set_speed_table.sv
module set_speed_table #(
    parameter int unsigned NUM_PRESETS = 4,
    parameter int unsigned SPD_W       = 7,
    parameter logic [NUM_PRESETS*speed_loop_pkg::PRESET_FIELD_W-1:0] PRESET_LIST =
        {16'd12, 16'd9, 16'd6, 16'd3}
) (
    input  logic [$clog2(NUM_PRESETS)-1:0] sel,
    output logic [SPD_W-1:0]               set_val
);
    localparam int unsigned FW = speed_loop_pkg::PRESET_FIELD_W;

    logic [FW-1:0] pick;

    always_comb begin
        pick    = PRESET_LIST[sel*FW +: FW];
        set_val = SPD_W'(pick);
    end
endmodule

// File: rtl/speed_compare.sv
module speed_compare #(
    parameter int unsigned DIGITS = 2,
    parameter int unsigned SPD_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic [4*DIGITS-1:0]      speed_bcd,
    input  logic [SPD_W-1:0]         set_val,
    output speed_loop_pkg::step_dir_e dir,
    output logic                     flag_eq,
    output logic                     flag_gt,
    output logic                     flag_lt
);
    import speed_loop_pkg::*;

    localparam int unsigned BCD_W = 4 * DIGITS;

    typedef struct packed {
        logic [BCD_W-1:0] held;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [SPD_W-1:0] in_bin, held_bin;

    function automatic logic [SPD_W-1:0] bcd_to_bin(input logic [BCD_W-1:0] b);
        logic [SPD_W-1:0] acc;
        acc = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc = SPD_W'(acc * 10) + SPD_W'(b[i*4 +: 4]);
        end
        return acc;
    endfunction

    always_comb begin
        st_d     = st_q;
        in_bin   = bcd_to_bin(speed_bcd);
        held_bin = bcd_to_bin(st_q.held);
        if (sample_stb) begin
            st_d.held = speed_bcd;
        end
        if (in_bin < set_val) begin
            dir = STEP_UP;
        end else if (in_bin > set_val) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_HOLD;
        end
        flag_eq = (held_bin == set_val);
        flag_gt = (held_bin > set_val);
        flag_lt = (held_bin < set_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.held <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper #(
    parameter int unsigned DUTY_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_en,
    input  speed_loop_pkg::step_dir_e dir,
    output logic [DUTY_W-1:0]         duty
);
    import speed_loop_pkg::*;

    localparam logic [DUTY_W-1:0] DUTY_TOP = '1;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } stp_state_t;

    stp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            unique case (dir)
                STEP_UP:   if (st_q.duty != DUTY_TOP) st_d.duty = st_q.duty + 1'b1;
                STEP_DOWN: if (st_q.duty != '0)       st_d.duty = st_q.duty - 1'b1;
                default:   st_d.duty = st_q.duty;
            endcase
        end
        duty = st_q.duty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.duty <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_slot_gen.sv
module pwm_slot_gen #(
    parameter int unsigned DUTY_W      = 4,
    parameter int unsigned STEP_CYCLES = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_n
);
    localparam int unsigned STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
    localparam logic [DUTY_W-1:0] CODE_TOP  = '1;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [DUTY_W-1:0] slot;
        logic [DUTY_W-1:0] on_slots;
        logic              pin_n;
    } pwm_state_t;

    pwm_state_t st_d, st_q;
    logic              at_start;
    logic [DUTY_W-1:0] on_sel;

    // Top code reuses the on-time of the code below it.
    function automatic logic [DUTY_W-1:0] slots_for(input logic [DUTY_W-1:0] code);
        return (code == CODE_TOP) ? code : code + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        at_start = (st_q.step == '0) && (st_q.slot == '0);
        on_sel   = at_start ? slots_for(duty) : st_q.on_slots;

        st_d.on_slots = on_sel;
        st_d.pin_n    = !(st_q.slot < on_sel);

        if (st_q.step == STEP_LAST) begin
            st_d.step = '0;
            st_d.slot = st_q.slot + 1'b1;
        end else begin
            st_d.step = st_q.step + 1'b1;
        end
        pwm_n = st_q.pin_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.step     <= '0;
            st_q.slot     <= '0;
            st_q.on_slots <= DUTY_W'(1);
            st_q.pin_n    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/speed_loop_pwm.sv
module speed_loop_pwm #(
    parameter int unsigned DUTY_W      = 4,
    parameter int unsigned STEP_CYCLES = 500,
    parameter int unsigned DIGITS      = 2,
    parameter int unsigned NUM_PRESETS = 4,
    parameter logic [NUM_PRESETS*speed_loop_pkg::PRESET_FIELD_W-1:0] PRESET_LIST =
        {16'd12, 16'd9, 16'd6, 16'd3}
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sample_stb,
    input  logic [4*DIGITS-1:0]            speed_bcd,
    input  logic [$clog2(NUM_PRESETS)-1:0] set_sel,
    output logic                           pwm_n,
    output logic [DUTY_W-1:0]              duty,
    output logic                           spd_eq,
    output logic                           spd_gt,
    output logic                           spd_lt
);
    import speed_loop_pkg::*;

    localparam int unsigned SPD_W = $clog2(10 ** DIGITS);

    logic [SPD_W-1:0] set_val;
    step_dir_e        dir;

    set_speed_table #(
        .NUM_PRESETS (NUM_PRESETS),
        .SPD_W       (SPD_W),
        .PRESET_LIST (PRESET_LIST)
    ) u_table (
        .sel     (set_sel),
        .set_val (set_val)
    );

    speed_compare #(
        .DIGITS (DIGITS),
        .SPD_W  (SPD_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .speed_bcd  (speed_bcd),
        .set_val    (set_val),
        .dir        (dir),
        .flag_eq    (spd_eq),
        .flag_gt    (spd_gt),
        .flag_lt    (spd_lt)
    );

    duty_stepper #(
        .DUTY_W (DUTY_W)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (sample_stb),
        .dir     (dir),
        .duty    (duty)
    );

    pwm_slot_gen #(
        .DUTY_W      (DUTY_W),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .duty  (duty),
        .pwm_n (pwm_n)
    );
endmodule

// File: rtl/speed_loop_pwm_chk.sv
module speed_loop_pwm_chk #(
    parameter int unsigned DUTY_W      = 4,
    parameter int unsigned STEP_CYCLES = 500,
    parameter int unsigned DIGITS      = 2,
    parameter int unsigned NUM_PRESETS = 4,
    parameter logic [NUM_PRESETS*speed_loop_pkg::PRESET_FIELD_W-1:0] PRESET_LIST =
        {16'd12, 16'd9, 16'd6, 16'd3}
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sample_stb,
    input logic [4*DIGITS-1:0]            speed_bcd,
    input logic [$clog2(NUM_PRESETS)-1:0] set_sel,
    input logic                           pwm_n,
    input logic [DUTY_W-1:0]              duty,
    input logic                           spd_eq,
    input logic                           spd_gt,
    input logic                           spd_lt
);
    localparam int unsigned FW     = speed_loop_pkg::PRESET_FIELD_W;
    localparam int unsigned PERIOD = (2 ** DUTY_W) * STEP_CYCLES;
    localparam int unsigned RUN_W  = $clog2(PERIOD + 1);
    localparam logic [DUTY_W-1:0] TOP = '1;

    int unsigned   in_spd;
    int unsigned   set_spd;
    logic [RUN_W-1:0] low_run;

    always_comb begin
        in_spd = 0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            in_spd = in_spd * 10 + 32'(speed_bcd[i*4 +: 4]);
        end
        set_spd = 32'(PRESET_LIST[set_sel*FW +: FW]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pwm_n) begin
            low_run <= '0;
        end else if (low_run != RUN_W'(PERIOD)) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pwm_n && duty == '0));

    assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({spd_eq, spd_gt, spd_lt}) == 1);

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && in_spd < set_spd && duty != TOP) |=> duty == $past(duty) + 1'b1);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && in_spd > set_spd && duty != '0) |=> duty == $past(duty) - 1'b1);

    assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && in_spd == set_spd) |=> $stable(duty));

    assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(duty));

    assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == TOP) |=> duty != '0);

    assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> duty != TOP);

    assert_never_full_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        low_run < RUN_W'(PERIOD));
endmodule

bind speed_loop_pwm speed_loop_pwm_chk #(
    .DUTY_W      (DUTY_W),
    .STEP_CYCLES (STEP_CYCLES),
    .DIGITS      (DIGITS),
    .NUM_PRESETS (NUM_PRESETS),
    .PRESET_LIST (PRESET_LIST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .speed_bcd  (speed_bcd),
    .set_sel    (set_sel),
    .pwm_n      (pwm_n),
    .duty       (duty),
    .spd_eq     (spd_eq),
    .spd_gt     (spd_gt),
    .spd_lt     (spd_lt)
);

// File: tb/speed_loop_pwm_tb.sv
module speed_loop_pwm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 4;
    localparam int SLOTS      = 16;
    localparam int PER        = SLOTS * STEP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_stb = 1'b0;
    logic [7:0] speed_bcd = '0;
    logic [1:0] set_sel = '0;
    logic       pwm_n;
    logic [3:0] duty;
    logic       spd_eq, spd_gt, spd_lt;

    int total = 0;
    int bad   = 0;
    int exp_duty = 0;
    int exp_held = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    speed_loop_pwm #(.STEP_CYCLES(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .speed_bcd(speed_bcd),
        .set_sel(set_sel), .pwm_n(pwm_n), .duty(duty),
        .spd_eq(spd_eq), .spd_gt(spd_gt), .spd_lt(spd_lt)
    );

    function automatic int preset(input int sel);
        return (sel + 1) * 3;
    endfunction

    function automatic int step_model(input int d, input int spd, input int setv);
        if (spd < setv) return (d == 15) ? 15 : d + 1;
        if (spd > setv) return (d == 0) ? 0 : d - 1;
        return d;
    endfunction

    function automatic int low_for(input int code);
        return ((code == 15) ? 15 : code + 1) * STEP;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        int s;
        int f_exp, f_act;
        s = preset(int'(set_sel));
        f_exp = (exp_held == s) ? 4 : ((exp_held > s) ? 2 : 1);
        f_act = {29'd0, spd_eq, spd_gt, spd_lt};
        check(f_act == f_exp, req, f_act, f_exp);
    endtask

    task automatic strobe(input int spd);
        speed_bcd  = {4'(spd / 10), 4'(spd % 10)};
        sample_stb = 1'b1;
        exp_duty   = step_model(exp_duty, spd, preset(int'(set_sel)));
        exp_held   = spd;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic measure(output int low, output int per);
        logic prev;
        prev = pwm_n;
        @(negedge clk);
        while (!(prev && !pwm_n)) begin
            prev = pwm_n;
            @(negedge clk);
        end
        low = 0;
        per = 0;
        while (!pwm_n) begin low++; per++; @(negedge clk); end
        while (pwm_n)  begin per++; @(negedge clk); end
    endtask

    task automatic drive_to(input int code);
        set_sel = 2'd1;
        while (exp_duty < code) strobe(0);
        while (exp_duty > code) strobe(50);
    endtask

    task automatic check_pwm(input string req);
        int lo, pr;
        measure(lo, pr);
        measure(lo, pr);
        check(lo == low_for(exp_duty), req, lo, low_for(exp_duty));
        check(pr == PER, "R7 period", pr, PER);
    endtask

    initial begin
        int lo, pr, old_code;
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_n == 1'b1, "R1 pwm_n in reset", int'(pwm_n), 1);
        check(duty == 4'd0, "R1 duty in reset", int'(duty), 0);
        check(spd_lt == 1'b1, "R1 latch cleared", int'(spd_lt), 1);
        rst_n = 1'b1;

        // R2/R3: presets via flags with a held speed of 6
        strobe(6);
        for (int s = 0; s < 4; s++) begin
            set_sel = 2'(s);
            @(negedge clk);
            check_flags("R2 preset select");
            check(duty == 4'(exp_duty), "R5 set_sel alone", int'(duty), exp_duty);
        end

        // R4/R3: random strobes
        for (int i = 0; i < 60; i++) begin
            int spd;
            set_sel = 2'($urandom_range(0, 3));
            spd = $urandom_range(0, 20);
            strobe(spd);
            check(duty == 4'(exp_duty), "R4 duty step", int'(duty), exp_duty);
            check_flags("R3 flags");
            repeat ($urandom_range(0, 3)) @(negedge clk);
            check(duty == 4'(exp_duty), "R5 no strobe hold", int'(duty), exp_duty);
        end

        // R6: saturation at both rails
        set_sel = 2'd3;
        for (int i = 0; i < 20; i++) strobe(0);
        check(duty == 4'd15, "R6 top saturate", int'(duty), 15);
        check_pwm("R9 code 15 low time");
        drive_to(14);
        check_pwm("R9 code 14 low time");
        for (int i = 0; i < 20; i++) strobe(99);
        check(duty == 4'd0, "R6 bottom saturate", int'(duty), 0);
        check_pwm("R8 code 0 low time");

        // R8: several mid codes
        for (int k = 0; k < 4; k++) begin
            drive_to($urandom_range(1, 13));
            check_pwm("R8 low time");
        end

        // R10: change during a running period
        drive_to(3);
        check_pwm("R8 code 3");
        old_code = exp_duty;
        fork
            measure(lo, pr);
            begin
                @(negedge pwm_n);
                @(negedge clk);
                strobe(0);
                strobe(0);
                strobe(0);
            end
        join
        check(lo == low_for(old_code), "R10 running period unchanged", lo, low_for(old_code));
        check(exp_duty == 6, "R10 model", exp_duty, 6);
        check_pwm("R10 next period uses new code");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule